// File: doc/BRIEF.md
# Serial Memory Slave Front End with Pause Control

This block is the bit-level front end of a serial memory slave in SPI mode 0. It oversamples chip select, serial clock, serial input and the pause pin with the system clock. Incoming bits are taken on rising serial-clock edges, most significant bit first. The block assembles an 8-bit opcode, then an address of `ADDR_W` bits, then any number of data bytes, and hands each one to the command logic through a parallel side. For reads, the command logic supplies a byte each time it is asked. The block shifts that byte out, most significant bit first, on falling serial-clock edges.

A low level on `hold_n` pauses a transfer. While paused, serial clock and input are ignored and the output enable is dropped. The pause starts and ends only while the serial clock is low. The transfer then continues at exactly the bit where it stopped. Raising chip select at any time, including during a pause, aborts the transfer. The next selection starts again with opcode bit 7.

Top module: `spi_hold_slave`

## Requirements
- R1: After reset, and in every cycle after chip select has been seen high, `so_oe` is 0, the bit position returns to opcode bit 7, and no partial word is ever reported.
- R2: The first 8 bits sampled on rising `sck` after `cs_n` falls form `op_code`, with the first bit as bit 7, and `op_valid` pulses for one cycle.
- R3: The next `ADDR_W` bits form `addr`, with the first bit as the most significant, and `addr_valid` pulses for one cycle.
- R4: Each further group of 8 bits forms `wr_data`, with the first bit as bit 7, and `wr_valid` pulses for one cycle per byte.
- R5: `tx_req` pulses together with `addr_valid` and with each `wr_valid`. `tx_data` is captured in that cycle and driven on `so` MSB first, one bit per falling `sck`, starting at the falling edge that follows the last address bit. Once that edge has passed, `so_oe` is 1 while `tx_en` is 1.
- R6: When `hold_n` is low while `sck` is low, the block enters the paused state. In that state `sck` and `si` have no effect on any later output, and `so_oe` is 0.
- R7: When `hold_n` falls while `sck` is high, the pause does not begin until `sck` is next low. `so_oe` stays 1 until then, and the falling edge that ends that high phase is still processed.
- R8: A pause ends only when `hold_n` is high while `sck` is low. Raising `hold_n` while `sck` is high keeps `so_oe` at 0. After release, the next accepted bit is the one that followed the last bit taken before the pause. A read paused inside the address returns the same bytes as an uninterrupted read.
- R9: Raising `cs_n` during a pause discards the partial transfer. No `op_valid` results from it, and the next selection decodes a complete new opcode.
- R10: With `tx_en` at 0, `so_oe` stays 0 throughout a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock, idle low |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Pause request, active low |
| so | output | 1 | Serial data out value |
| so_oe | output | 1 | Output enable for `so`; 0 means the pad floats |
| tx_en | input | 1 | Command logic allows read data to be driven |
| tx_data | input | 8 | Byte to transmit, captured when `tx_req` is 1 |
| tx_req | output | 1 | Request for the next transmit byte |
| op_code | output | 8 | Last received opcode |
| op_valid | output | 1 | One-cycle pulse: `op_code` updated |
| addr | output | ADDR_W | Last received address |
| addr_valid | output | 1 | One-cycle pulse: `addr` updated |
| wr_data | output | 8 | Last received data byte |
| wr_valid | output | 1 | One-cycle pulse: `wr_data` updated |

## Verification
A pin change reaches the edge detector after `SYNC_STAGES` clocks. The parallel outputs and `so` change one clock later, so each result follows its `sck` edge by `SYNC_STAGES`+1 clocks (3 by default). The bench keeps every `sck` level for 8 clocks. It reads `so` and `so_oe` at the end of each low phase, just before the next rising edge. The pause state is checked at the end of a full level after each `hold_n` change. The one-cycle pulses are latched by a monitor on each clock, and their values are compared once chip select has risen at the end of the transfer.

// File: rtl/spi_hold_pkg.sv
package spi_hold_pkg;
   typedef enum logic [1:0] {
      PH_OP   = 2'd0,
      PH_ADDR = 2'd1,
      PH_DATA = 2'd2
   } phase_e;
endpackage

// File: rtl/spi_hold_sync.sv
module spi_hold_sync #(
   parameter int          W       = 4,
   parameter int          STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   if (STAGES < 1) begin : g_bad_stages
      $error("spi_hold_sync: STAGES must be at least 1");
   end

   logic [W-1:0] chain_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[0] <= RST_VAL;
            else        chain_q[0] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= RST_VAL;
            else        chain_q[s] <= chain_q[s-1];
         end
      end
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/spi_hold_ctrl.sv
module spi_hold_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_i,
   input  logic sck_i,
   input  logic hold_n_i,
   output logic held_o,
   output logic rise_o,
   output logic fall_o
);
   logic sck_q;
   logic held_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_q  <= 1'b0;
         held_q <= 1'b0;
      end else begin
         sck_q <= sck_i;
         if (cs_i)        held_q <= 1'b0;
         else if (!sck_i) held_q <= ~hold_n_i;
      end
   end

   assign held_o = held_q;
   assign rise_o = ~cs_i & ~held_q &  sck_i & ~sck_q;
   assign fall_o = ~cs_i & ~held_q & ~sck_i &  sck_q;

   // R7 R8
   hold_sck_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_i && sck_i) |=> $stable(held_q));

   // R9
   cs_release_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_i |=> !held_q);
endmodule

// File: rtl/spi_hold_rx.sv
module spi_hold_rx
   import spi_hold_pkg::*;
#(
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_i,
   input  logic              held_i,
   input  logic              rise_i,
   input  logic              si_i,
   output logic [7:0]        op_code_o,
   output logic              op_valid_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic              addr_valid_o,
   output logic [7:0]        wr_data_o,
   output logic              wr_valid_o,
   output logic              load_o,
   output logic              data_ph_o
);
   localparam int SH_W  = (ADDR_W > 8) ? ADDR_W : 8;
   localparam int CNT_W = $clog2(SH_W);

   phase_e           phase_q;
   logic [CNT_W-1:0] cnt_q;
   logic [SH_W-1:0]  sh_q;
   logic [SH_W-1:0]  sh_nxt;
   logic             last_bit;

   assign sh_nxt = {sh_q[SH_W-2:0], si_i};

   always_comb begin
      unique case (phase_q)
         PH_OP:   last_bit = (cnt_q == CNT_W'(7));
         PH_ADDR: last_bit = (cnt_q == CNT_W'(ADDR_W - 1));
         default: last_bit = (cnt_q == CNT_W'(7));
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q      <= PH_OP;
         cnt_q        <= '0;
         sh_q         <= '0;
         op_code_o    <= '0;
         addr_o       <= '0;
         wr_data_o    <= '0;
         op_valid_o   <= 1'b0;
         addr_valid_o <= 1'b0;
         wr_valid_o   <= 1'b0;
         load_o       <= 1'b0;
      end else begin
         op_valid_o   <= 1'b0;
         addr_valid_o <= 1'b0;
         wr_valid_o   <= 1'b0;
         load_o       <= 1'b0;
         if (cs_i) begin
            phase_q <= PH_OP;
            cnt_q   <= '0;
            sh_q    <= '0;
         end else if (rise_i) begin
            sh_q <= sh_nxt;
            if (last_bit) begin
               cnt_q <= '0;
               unique case (phase_q)
                  PH_OP: begin
                     op_code_o  <= sh_nxt[7:0];
                     op_valid_o <= 1'b1;
                     phase_q    <= PH_ADDR;
                  end
                  PH_ADDR: begin
                     addr_o       <= sh_nxt[ADDR_W-1:0];
                     addr_valid_o <= 1'b1;
                     load_o       <= 1'b1;
                     phase_q      <= PH_DATA;
                  end
                  default: begin
                     wr_data_o  <= sh_nxt[7:0];
                     wr_valid_o <= 1'b1;
                     load_o     <= 1'b1;
                  end
               endcase
            end else begin
               cnt_q <= cnt_q + CNT_W'(1);
            end
         end
      end
   end

   assign data_ph_o = (phase_q == PH_DATA);

   // R6
   frozen_in_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (held_i && !cs_i) |=> ($stable(cnt_q) && $stable(sh_q) && $stable(phase_q)));

   // R1
   cs_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_i |=> (cnt_q == '0 && phase_q == PH_OP && sh_q == '0));

   // R2 R3 R4
   one_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({op_valid_o, addr_valid_o, wr_valid_o}));
endmodule

// File: rtl/spi_hold_tx.sv
module spi_hold_tx (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cs_i,
   input  logic       held_i,
   input  logic       fall_i,
   input  logic       data_ph_i,
   input  logic       load_i,
   input  logic [7:0] tx_data_i,
   input  logic       tx_en_i,
   output logic       so_o,
   output logic       so_oe_o
);
   logic [7:0] sh_q;
   logic       bit_q;
   logic       live_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q   <= '0;
         bit_q  <= 1'b0;
         live_q <= 1'b0;
      end else if (cs_i) begin
         sh_q   <= '0;
         bit_q  <= 1'b0;
         live_q <= 1'b0;
      end else if (load_i) begin
         sh_q <= tx_data_i;
      end else if (fall_i && data_ph_i) begin
         bit_q  <= sh_q[7];
         sh_q   <= {sh_q[6:0], 1'b0};
         live_q <= 1'b1;
      end
   end

   assign so_o    = bit_q;
   assign so_oe_o = live_q & tx_en_i & ~held_i & ~cs_i;

   // R1 R9
   cs_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_i |=> !live_q);

   // R5
   load_no_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |-> !fall_i);
endmodule

// File: rtl/spi_hold_slave.sv
module spi_hold_slave #(
   parameter int ADDR_W      = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              sck,
   input  logic              si,
   input  logic              hold_n,
   output logic              so,
   output logic              so_oe,
   input  logic              tx_en,
   input  logic [7:0]        tx_data,
   output logic              tx_req,
   output logic [7:0]        op_code,
   output logic              op_valid,
   output logic [ADDR_W-1:0] addr,
   output logic              addr_valid,
   output logic [7:0]        wr_data,
   output logic              wr_valid
);
   if (ADDR_W < 1 || ADDR_W > 32) begin : g_bad_addr_w
      $error("spi_hold_slave: ADDR_W must lie in 1..32");
   end
   if (SYNC_STAGES < 1) begin : g_bad_sync
      $error("spi_hold_slave: SYNC_STAGES must be at least 1");
   end

   localparam int         PIN_W   = 4;
   localparam logic [3:0] PIN_RST = 4'b1001;

   logic [PIN_W-1:0] pins_s;
   logic cs_s, sck_s, si_s, hold_n_s;
   logic held, rise, fall, data_ph;

   spi_hold_sync #(.W(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({cs_n, sck, si, hold_n}),
      .q_o   (pins_s)
   );

   assign {cs_s, sck_s, si_s, hold_n_s} = pins_s;

   spi_hold_ctrl u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .cs_i     (cs_s),
      .sck_i    (sck_s),
      .hold_n_i (hold_n_s),
      .held_o   (held),
      .rise_o   (rise),
      .fall_o   (fall)
   );

   spi_hold_rx #(.ADDR_W(ADDR_W)) u_rx (
      .clk          (clk),
      .rst_n        (rst_n),
      .cs_i         (cs_s),
      .held_i       (held),
      .rise_i       (rise),
      .si_i         (si_s),
      .op_code_o    (op_code),
      .op_valid_o   (op_valid),
      .addr_o       (addr),
      .addr_valid_o (addr_valid),
      .wr_data_o    (wr_data),
      .wr_valid_o   (wr_valid),
      .load_o       (tx_req),
      .data_ph_o    (data_ph)
   );

   spi_hold_tx u_tx (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs_i      (cs_s),
      .held_i    (held),
      .fall_i    (fall),
      .data_ph_i (data_ph),
      .load_i    (tx_req),
      .tx_data_i (tx_data),
      .tx_en_i   (tx_en),
      .so_o      (so),
      .so_oe_o   (so_oe)
   );
endmodule

// File: tb/spi_hold_slave_tb.sv
module spi_hold_slave_tb_top;
   localparam int CLK_P  = 10;
   localparam int HALF   = 8;
   localparam int ADDR_W = 16;
   localparam int NRAND  = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1, tx_en = 1'b0;
   logic so, so_oe, tx_req, op_valid, addr_valid, wr_valid;
   logic [7:0] tx_data, op_code, wr_data;
   logic [ADDR_W-1:0] addr;

   int total = 0, bad = 0;
   bit done = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   spi_hold_slave #(.ADDR_W(ADDR_W), .SYNC_STAGES(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .hold_n(hold_n),
      .so(so), .so_oe(so_oe), .tx_en(tx_en), .tx_data(tx_data), .tx_req(tx_req),
      .op_code(op_code), .op_valid(op_valid), .addr(addr), .addr_valid(addr_valid),
      .wr_data(wr_data), .wr_valid(wr_valid)
   );

   function automatic logic [7:0] patt(input logic [ADDR_W-1:0] a);
      return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h3C;
   endfunction

   // Command-logic model: byte k of a read returns patt(addr + k)
   logic [ADDR_W-1:0] rd_idx = '0;
   assign tx_data = patt(addr + (addr_valid ? '0 : rd_idx));

   int         n_op = 0, n_addr = 0, n_wr = 0;
   logic [7:0] mon_op;
   logic [ADDR_W-1:0] mon_addr;
   logic [7:0] mon_wr [256];

   always @(posedge clk) begin
      if (addr_valid)  rd_idx <= ADDR_W'(1);
      else if (tx_req) rd_idx <= rd_idx + ADDR_W'(1);
      if (op_valid)   begin mon_op <= op_code; n_op <= n_op + 1; end
      if (addr_valid) begin mon_addr <= addr; n_addr <= n_addr + 1; end
      if (wr_valid)   begin mon_wr[n_wr % 256] <= wr_data; n_wr <= n_wr + 1; end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   // Pause while sck is low, wiggle sck/si, release while low (R6)
   task automatic low_hold();
      hold_n = 1'b0;
      tick(HALF);
      chk(so_oe == 1'b0, "R6 oe in pause", so_oe, 0);
      for (int k = 0; k < 2; k++) begin
         sck = 1'b1; si = 1'($urandom); tick(HALF);
         sck = 1'b0; si = 1'($urandom); tick(HALF);
      end
      chk(so_oe == 1'b0, "R6 oe after wiggle", so_oe, 0);
      hold_n = 1'b1;
      tick(HALF);
   endtask

   // One bit: hmode 0 none, 1 pause before bit, 2 hold_n falls during sck high
   task automatic xbit(input logic mosi, input int hmode, input bit rd_ph,
                       output logic miso, output logic oe);
      if (hmode == 1) low_hold();
      si = mosi;
      tick(HALF);
      miso = so; oe = so_oe;
      sck = 1'b1;
      tick(HALF);
      if (hmode == 2) begin
         hold_n = 1'b0;
         tick(HALF);
         if (rd_ph) chk(so_oe == 1'b1, "R7 pause deferred while sck high", so_oe, 1);
         sck = 1'b0;
         tick(HALF);
         chk(so_oe == 1'b0, "R7 pause taken at sck low", so_oe, 0);
         sck = 1'b1; si = ~si;
         tick(HALF);
         hold_n = 1'b1;
         tick(HALF);
         chk(so_oe == 1'b0, "R8 release gated by sck high", so_oe, 0);
         sck = 1'b0;
         tick(HALF);
      end else begin
         sck = 1'b0;
      end
   endtask

   // Full transfer; returns the read bytes for comparison
   task automatic xfer(input logic [7:0] op, input logic [ADDR_W-1:0] a, input int nb,
                       input bit rd, input bit en, input int h_at, input int h_mode,
                       output logic [7:0] rb [4]);
      int nbits = 8 + ADDR_W + 8*nb;
      int op0 = n_op, ad0 = n_addr, wr0 = n_wr;
      logic [7:0] wb [4];
      bit oe_all = 1'b1, oe_any = 1'b0;
      for (int k = 0; k < 4; k++) begin wb[k] = 8'($urandom); rb[k] = '0; end
      tx_en = en;
      cs_n = 1'b0;
      tick(HALF);
      for (int i = 0; i < nbits; i++) begin
         logic mosi, miso, oe;
         bit dph = (i >= 8 + ADDR_W);
         int di = i - 8 - ADDR_W;
         if (i < 8)          mosi = op[7-i];
         else if (!dph)      mosi = a[ADDR_W-1-(i-8)];
         else                mosi = wb[di/8][7-(di%8)];
         xbit(mosi, (i == h_at) ? h_mode : 0, dph && rd && en, miso, oe);
         if (dph) begin
            rb[di/8][7-(di%8)] = miso;
            oe_all &= oe;
            oe_any |= oe;
         end
      end
      cs_n = 1'b1;
      tick(HALF);
      chk(so_oe == 1'b0, "R1 oe off after cs high", so_oe, 0);
      chk(n_op == op0 + 1 && mon_op == op, "R2 opcode", mon_op, op);
      chk(n_addr == ad0 + 1 && mon_addr == a, "R3 address", mon_addr, a);
      chk(n_wr == wr0 + nb, "R4 byte count", n_wr - wr0, nb);
      if (!rd) begin
         for (int k = 0; k < nb; k++)
            chk(mon_wr[(wr0 + k) % 256] == wb[k], "R4 write byte", mon_wr[(wr0 + k) % 256], wb[k]);
      end else if (en) begin
         if (nb > 0) chk(oe_all, "R5 oe during read data", oe_all, 1);
         for (int k = 0; k < nb; k++) begin
            logic [7:0] e = patt(a + ADDR_W'(k));
            chk(rb[k] == e, (h_mode != 0) ? "R8 read data across pause" : "R5 read data", rb[k], e);
         end
      end else begin
         chk(!oe_any, "R10 oe stays low without tx_en", oe_any, 0);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] ref_rb [4];
      logic [7:0] got_rb [4];
      int op0;
      void'($urandom(32'h5EED_0042));
      tick(5);
      rst_n = 1'b1;
      tick(4);
      // R1 reset state
      chk(so_oe == 1'b0, "R1 reset oe", so_oe, 0);
      chk(op_code == 8'h00 && addr == '0 && wr_data == 8'h00, "R1 reset words", {op_code, wr_data}, 0);
      chk(!op_valid && !addr_valid && !wr_valid && !tx_req, "R1 reset pulses",
          {op_valid, addr_valid, wr_valid, tx_req}, 0);

      // R4 plain write
      xfer(8'h02, 16'h1234, 3, 1'b0, 1'b0, -1, 0, got_rb);
      // R5 plain read, reference for the paused read
      xfer(8'h03, 16'h3A5C, 3, 1'b1, 1'b1, -1, 0, ref_rb);
      // R8 same read paused after address bit 5 was taken
      xfer(8'h03, 16'h3A5C, 3, 1'b1, 1'b1, 8 + 6, 1, got_rb);
      for (int k = 0; k < 3; k++)
         chk(got_rb[k] == ref_rb[k], "R8 paused read matches plain read", got_rb[k], ref_rb[k]);
      // R7 pause requested while sck high, inside read data
      xfer(8'h0B, 16'hFF01, 2, 1'b1, 1'b1, 8 + ADDR_W + 3, 2, got_rb);
      // R7 same inside the opcode
      xfer(8'hA7, 16'h0F0F, 1, 1'b0, 1'b0, 4, 2, got_rb);
      // R10 read with transmit disabled
      xfer(8'h03, 16'h0100, 2, 1'b1, 1'b0, -1, 0, got_rb);

      // R9 abort during pause in the middle of an opcode
      op0 = n_op;
      tx_en = 1'b1;
      cs_n = 1'b0;
      tick(HALF);
      for (int i = 0; i < 5; i++) begin
         logic m, o;
         xbit(1'b1, 0, 1'b0, m, o);
      end
      hold_n = 1'b0;
      tick(HALF);
      cs_n = 1'b1;
      tick(HALF);
      hold_n = 1'b1;
      tick(HALF);
      chk(so_oe == 1'b0, "R9 oe after abort", so_oe, 0);
      chk(n_op == op0, "R9 no opcode from aborted transfer", n_op - op0, 0);
      xfer(8'h5A, 16'hC003, 1, 1'b0, 1'b0, -1, 0, got_rb);

      // Random transfers with random pause placement
      for (int t = 0; t < NRAND; t++) begin
         bit rd = 1'($urandom);
         int nb = 1 + int'($urandom_range(0, 2));
         int nbits = 8 + ADDR_W + 8*nb;
         int hm = int'($urandom_range(0, 2));
         int ha = int'($urandom_range(0, nbits - 1));
         xfer(8'($urandom), ADDR_W'($urandom), nb, rd, rd, ha, hm, got_rb);
      end

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule